// File: doc/BRIEF.md
# Accumulator Transfer and Limiter Register Bank

This block is the register bank at the front of a 24-bit fixed-point DSP data path. It holds two 56-bit accumulators and four 24-bit input registers. Each accumulator has three parts: an 8-bit guard byte at the top, a 24-bit high word and a 24-bit low word. On each clock edge the bank can perform one register-to-accumulator transfer, one parallel move into an input register, and one 56-bit load from the arithmetic result bus. All of these read the values held before the edge and commit together on that edge.

The transfer has two modes. The exact mode copies a full accumulator, with no scaling and no saturation. The limited mode models a plain move and sends an accumulator source through the saturating limiter. A parallel move always reads an accumulator source through the limiter. Limiting caused by a parallel move or by a limited-mode transfer sets a sticky limit flag in the condition-code byte. Only reset clears the flag.

Top module: `dsp_acc_xfer`

## Requirements
- R1: After the active-low asynchronous reset, both accumulators, all four input registers and ccr_o are zero.
- R2: An exact-mode transfer (xfer_sat_i=0) whose source is an accumulator (source code 0=A, 1=B) writes all 56 bits of that accumulator unchanged into the destination (xfer_dst_i 0=A, 1=B). For example, 01_234567_89ABCD stays 01_234567_89ABCD.
- R3: A transfer whose source is an input register (source codes 2=X0, 3=X1, 4=Y0, 5=Y1) writes that register into the high word of the destination in both modes. The guard byte is filled with the register's bit 23 and the low word is cleared.
- R4: The limiter flags overflow when bits 55..47 of an accumulator are not all equal. On overflow it outputs 7FFFFF if bit 55 is 0 and 800000 if bit 55 is 1. Without overflow it outputs bits 47..24.
- R5: A limited-mode transfer (xfer_sat_i=1) from an accumulator writes the limited 24-bit word into the destination with the R3 layout. If limiting occurred, it sets the limit flag.
- R6: A parallel move (pm_valid_i=1) writes the input register chosen by pm_dst_i (0=X0, 1=X1, 2=Y0, 3=Y1). With source code 0 or 1 it writes the limited word of that accumulator. With codes 2..5 it writes that input register's value. With codes 6 and 7 it writes pm_data_i.
- R7: The limit flag appears at ccr_o bit 6, and the other ccr_o bits read 0. The flag is set when a parallel move from an accumulator performs limiting, and it stays set until reset. An exact-mode transfer never sets it, even from an out-of-range accumulator.
- R8: Every operation in one cycle reads the register values from before the edge. For example, a parallel move that reads B in the same cycle as a transfer into B receives B's old value.
- R9: acc_we_i loads acc_wdata_i into the accumulator chosen by acc_wsel_i (0=A, 1=B). When a valid transfer writes the same accumulator in the same cycle, the transfer wins and the load has no effect.
- R10: A transfer with source code 6 or 7 writes no accumulator and leaves the limit flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_valid_i | input | 1 | Transfer command strobe |
| xfer_sat_i | input | 1 | 0 = exact transfer, 1 = limited plain move |
| xfer_src_i | input | 3 | Transfer source code |
| xfer_dst_i | input | 1 | Transfer destination accumulator |
| pm_valid_i | input | 1 | Parallel move strobe |
| pm_src_i | input | 3 | Parallel move source code |
| pm_dst_i | input | 2 | Parallel move destination register |
| pm_data_i | input | 24 | External word for the parallel move |
| acc_we_i | input | 1 | Result bus load strobe |
| acc_wsel_i | input | 1 | Accumulator chosen for the load |
| acc_wdata_i | input | 56 | Result bus load value |
| acc_a_o | output | 56 | Accumulator A |
| acc_b_o | output | 56 | Accumulator B |
| x0_o | output | 24 | Register X0 |
| x1_o | output | 24 | Register X1 |
| y0_o | output | 24 | Register Y0 |
| y1_o | output | 24 | Register Y1 |
| ccr_o | output | 8 | Condition-code byte, limit flag at bit 6 |

## Verification
The assertions check on every cycle that:
- an exact transfer copies the accumulator bit for bit;
- a register source arrives sign-extended with its low word cleared;
- the limit flag never falls and an exact transfer on its own never raises it;
- a parallel move from an accumulator takes the limiter word;
- a transfer beats a load to the same accumulator;
- an unused source code leaves both accumulators as they were;
- the limiter keeps the sign of its input.

Only the bench scenarios can show the actual saturated values for positive and negative overflow, and the reset clearing the flag. The same applies to the pre-edge reads when a transfer and a parallel move share an accumulator, and to the result of the combined transfer, parallel move and flag update.

// File: rtl/dsp_acc_xfer_pkg.sv
package dsp_acc_xfer_pkg;
  typedef enum logic [2:0] {
    SRC_A   = 3'd0,
    SRC_B   = 3'd1,
    SRC_X0  = 3'd2,
    SRC_X1  = 3'd3,
    SRC_Y0  = 3'd4,
    SRC_Y1  = 3'd5,
    SRC_EXT = 3'd6,
    SRC_RSV = 3'd7
  } src_e;

  localparam int unsigned NUM_ACC = 2;
  localparam int unsigned NUM_REG = 4;
  localparam int unsigned CCR_LIM_BIT = 6;
endpackage

// File: rtl/dsp_limiter.sv
module dsp_limiter #(
  parameter int unsigned DW = 24,
  parameter int unsigned EW = 8
) (
  input  logic [EW+2*DW-1:0] acc_i,
  output logic [DW-1:0]      word_o,
  output logic               lim_o
);
  localparam int unsigned AW = EW + 2*DW;
  localparam int unsigned TW = EW + 1;

  logic [TW-1:0] top;
  logic          neg;

  assign top = acc_i[AW-1 -: TW];
  assign neg = acc_i[AW-1];

  // guard byte plus high-word msb must agree, else the value does not fit
  assign lim_o  = !((&top) || !(|top));
  assign word_o = lim_o ? {neg, {(DW-1){~neg}}} : acc_i[2*DW-1 -: DW];

  always_comb begin
    if (!$isunknown(acc_i)) begin
      // R4
      lim_sign_keep_chk: assert (word_o[DW-1] == acc_i[AW-1]);
    end
  end
endmodule

// File: rtl/dsp_src_mux.sv
module dsp_src_mux
  import dsp_acc_xfer_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned EW = 8
) (
  input  logic [1:0][EW+2*DW-1:0] acc_i,
  input  logic [1:0][DW-1:0]      lim_word_i,
  input  logic [1:0]              lim_hit_i,
  input  logic [3:0][DW-1:0]      reg_i,
  input  logic [2:0]              xfer_src_i,
  input  logic                    xfer_sat_i,
  input  logic [2:0]              pm_src_i,
  input  logic [DW-1:0]           pm_data_i,
  output logic [EW+2*DW-1:0]      xfer_val_o,
  output logic                    xfer_ok_o,
  output logic                    xfer_lim_o,
  output logic [DW-1:0]           pm_val_o,
  output logic                    pm_lim_o
);
  localparam int unsigned AW = EW + 2*DW;

  logic [2:0]    xr_idx, pr_idx;
  logic [DW-1:0] xfer_word;

  assign xr_idx = xfer_src_i - 3'd2;
  assign pr_idx = pm_src_i - 3'd2;

  always_comb begin
    xfer_ok_o  = 1'b1;
    xfer_lim_o = 1'b0;
    xfer_word  = '0;
    xfer_val_o = '0;
    case (src_e'(xfer_src_i))
      SRC_A, SRC_B: begin
        if (xfer_sat_i) begin
          xfer_word  = lim_word_i[xfer_src_i[0]];
          xfer_lim_o = lim_hit_i[xfer_src_i[0]];
          xfer_val_o = {{EW{xfer_word[DW-1]}}, xfer_word, {DW{1'b0}}};
        end else begin
          // exact path skips the limiter
          xfer_val_o = acc_i[xfer_src_i[0]];
        end
      end
      SRC_X0, SRC_X1, SRC_Y0, SRC_Y1: begin
        xfer_word  = reg_i[xr_idx[1:0]];
        xfer_val_o = {{EW{xfer_word[DW-1]}}, xfer_word, {DW{1'b0}}};
      end
      default: xfer_ok_o = 1'b0;
    endcase
  end

  always_comb begin
    pm_lim_o = 1'b0;
    case (src_e'(pm_src_i))
      SRC_A, SRC_B: begin
        pm_val_o = lim_word_i[pm_src_i[0]];
        pm_lim_o = lim_hit_i[pm_src_i[0]];
      end
      SRC_X0, SRC_X1, SRC_Y0, SRC_Y1: pm_val_o = reg_i[pr_idx[1:0]];
      default: pm_val_o = pm_data_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({xfer_src_i, acc_i}) && xfer_ok_o && !xfer_sat_i && xfer_src_i < 3'd2) begin
      // R2
      exact_path_chk: assert (xfer_val_o == acc_i[xfer_src_i[0]]);
    end
  end
endmodule

// File: rtl/dsp_acc_xfer.sv
module dsp_acc_xfer
  import dsp_acc_xfer_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned EW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 xfer_valid_i,
  input  logic                 xfer_sat_i,
  input  logic [2:0]           xfer_src_i,
  input  logic                 xfer_dst_i,
  input  logic                 pm_valid_i,
  input  logic [2:0]           pm_src_i,
  input  logic [1:0]           pm_dst_i,
  input  logic [DW-1:0]        pm_data_i,
  input  logic                 acc_we_i,
  input  logic                 acc_wsel_i,
  input  logic [EW+2*DW-1:0]   acc_wdata_i,
  output logic [EW+2*DW-1:0]   acc_a_o,
  output logic [EW+2*DW-1:0]   acc_b_o,
  output logic [DW-1:0]        x0_o,
  output logic [DW-1:0]        x1_o,
  output logic [DW-1:0]        y0_o,
  output logic [DW-1:0]        y1_o,
  output logic [7:0]           ccr_o
);
  localparam int unsigned AW = EW + 2*DW;

  logic [NUM_ACC-1:0][AW-1:0] acc_q, acc_d;
  logic [NUM_REG-1:0][DW-1:0] reg_q, reg_d;
  logic                       lim_q, lim_d;

  logic [NUM_ACC-1:0][DW-1:0] lim_word;
  logic [NUM_ACC-1:0]         lim_hit;
  logic [AW-1:0]              xfer_val;
  logic                       xfer_ok, xfer_lim;
  logic [DW-1:0]              pm_val;
  logic                       pm_lim;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_lim
    dsp_limiter #(.DW(DW), .EW(EW)) i_lim (
      .acc_i (acc_q[g]),
      .word_o(lim_word[g]),
      .lim_o (lim_hit[g])
    );
  end

  dsp_src_mux #(.DW(DW), .EW(EW)) i_mux (
    .acc_i     (acc_q),
    .lim_word_i(lim_word),
    .lim_hit_i (lim_hit),
    .reg_i     (reg_q),
    .xfer_src_i(xfer_src_i),
    .xfer_sat_i(xfer_sat_i),
    .pm_src_i  (pm_src_i),
    .pm_data_i (pm_data_i),
    .xfer_val_o(xfer_val),
    .xfer_ok_o (xfer_ok),
    .xfer_lim_o(xfer_lim),
    .pm_val_o  (pm_val),
    .pm_lim_o  (pm_lim)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc_nxt
    always_comb begin
      acc_d[g] = acc_q[g];
      if (acc_we_i && (acc_wsel_i == g[0])) acc_d[g] = acc_wdata_i;
      // transfer has priority over the result bus
      if (xfer_valid_i && xfer_ok && (xfer_dst_i == g[0])) acc_d[g] = xfer_val;
    end
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg_nxt
    assign reg_d[g] = (pm_valid_i && (pm_dst_i == g[1:0])) ? pm_val : reg_q[g];
  end

  assign lim_d = lim_q | (pm_valid_i & pm_lim) | (xfer_valid_i & xfer_ok & xfer_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      reg_q <= '0;
      lim_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      reg_q <= reg_d;
      lim_q <= lim_d;
    end
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign x0_o    = reg_q[0];
  assign x1_o    = reg_q[1];
  assign y0_o    = reg_q[2];
  assign y1_o    = reg_q[3];

  always_comb begin
    ccr_o              = '0;
    ccr_o[CCR_LIM_BIT] = lim_q;
  end

  // R2
  acc_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && !xfer_sat_i && (xfer_src_i < 3'd2))
    |=> acc_q[$past(xfer_dst_i)] == $past(acc_q[xfer_src_i[0]]));

  // R3
  reg_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && (xfer_src_i >= 3'd2) && (xfer_src_i <= 3'd5))
    |=> (acc_q[$past(xfer_dst_i)][AW-1 -: EW+1] == {(EW+1){acc_q[$past(xfer_dst_i)][2*DW-1]}})
        && (acc_q[$past(xfer_dst_i)][DW-1:0] == '0));

  // R7
  lim_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q |=> lim_q);

  // R7
  exact_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lim_q && !pm_valid_i && !(xfer_valid_i && xfer_sat_i)) |=> !lim_q);

  // R6
  pm_limited_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_valid_i && (pm_src_i < 3'd2))
    |=> reg_q[$past(pm_dst_i)] == $past(lim_word[pm_src_i[0]]));

  // R9
  xfer_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_i && xfer_valid_i && xfer_ok && (acc_wsel_i == xfer_dst_i))
    |=> acc_q[$past(xfer_dst_i)] == $past(xfer_val));

  // R10
  bad_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && (xfer_src_i > 3'd5) && !acc_we_i) |=> $stable(acc_q));
endmodule

// File: tb/test_dsp_acc_xfer.sv
`timescale 1ns/1ps
module test_dsp_acc_xfer;
  typedef struct packed {
    logic [55:0] a;
    logic [55:0] b;
    logic [23:0] x0, x1, y0, y1;
    logic [7:0]  ccr;
  } snap_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_valid = 1'b0, xfer_sat = 1'b0, xfer_dst = 1'b0;
  logic [2:0]  xfer_src = '0, pm_src = '0;
  logic        pm_valid = 1'b0, acc_we = 1'b0, acc_wsel = 1'b0;
  logic [1:0]  pm_dst = '0;
  logic [23:0] pm_data = '0;
  logic [55:0] acc_wdata = '0;
  logic [55:0] acc_a, acc_b;
  logic [23:0] x0, x1, y0, y1;
  logic [7:0]  ccr;

  int checks = 0;
  int errors = 0;

  snap_t exp_q[$];
  string tag_q[$];

  logic [55:0] ma, mb;
  logic [23:0] mr [4];
  logic        ml;

  always #2 clk = ~clk;

  dsp_acc_xfer i_dsp_acc_xfer (
    .clk_i(clk), .rst_ni(rst_ni),
    .xfer_valid_i(xfer_valid), .xfer_sat_i(xfer_sat), .xfer_src_i(xfer_src), .xfer_dst_i(xfer_dst),
    .pm_valid_i(pm_valid), .pm_src_i(pm_src), .pm_dst_i(pm_dst), .pm_data_i(pm_data),
    .acc_we_i(acc_we), .acc_wsel_i(acc_wsel), .acc_wdata_i(acc_wdata),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .x0_o(x0), .x1_o(x1), .y0_o(y0), .y1_o(y1), .ccr_o(ccr)
  );

  // R4 reference limiter
  function automatic logic [24:0] lim_ref(input logic [55:0] v);
    logic hit;
    hit = !((v[55:47] == 9'h000) || (v[55:47] == 9'h1FF));
    return {hit, hit ? (v[55] ? 24'h800000 : 24'h7FFFFF) : v[47:24]};
  endfunction

  function automatic logic [55:0] sx(input logic [23:0] w);
    return {{8{w[23]}}, w, 24'h0};
  endfunction

  function automatic snap_t model_snap();
    return '{a: ma, b: mb, x0: mr[0], x1: mr[1], y0: mr[2], y1: mr[3], ccr: {1'b0, ml, 6'b0}};
  endfunction

  function automatic snap_t dut_snap();
    return '{a: acc_a, b: acc_b, x0: x0, x1: x1, y0: y0, y1: y1, ccr: ccr};
  endfunction

  task automatic check(input string tag, input snap_t act, input snap_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected state pushed to the scoreboard
  task automatic step(input string tag,
                      input bit xv, input bit xs, input logic [2:0] xsrc, input bit xd,
                      input bit pv, input logic [2:0] psrc, input logic [1:0] pd, input logic [23:0] pdat,
                      input bit wv, input bit ws, input logic [55:0] wd);
    logic [55:0] na, nb, v;
    logic [23:0] nr [4];
    logic [24:0] lr;
    logic        nl, ok;
    @(negedge clk);
    xfer_valid = xv; xfer_sat = xs; xfer_src = xsrc; xfer_dst = xd;
    pm_valid = pv; pm_src = psrc; pm_dst = pd; pm_data = pdat;
    acc_we = wv; acc_wsel = ws; acc_wdata = wd;
    na = ma; nb = mb; nl = ml;
    for (int i = 0; i < 4; i++) nr[i] = mr[i];
    if (wv) begin
      if (ws) nb = wd; else na = wd;
    end
    if (xv) begin
      ok = 1'b1;
      v = '0;
      if (xsrc < 3'd2) begin
        if (xs) begin
          lr = lim_ref(xsrc[0] ? mb : ma);
          v = sx(lr[23:0]);
          nl = nl | lr[24];
        end else v = xsrc[0] ? mb : ma;
      end else if (xsrc <= 3'd5) v = sx(mr[xsrc - 3'd2]);
      else ok = 1'b0;
      if (ok) begin
        if (xd) nb = v; else na = v;
      end
    end
    if (pv) begin
      if (psrc < 3'd2) begin
        lr = lim_ref(psrc[0] ? mb : ma);
        nr[pd] = lr[23:0];
        nl = nl | lr[24];
      end else if (psrc <= 3'd5) nr[pd] = mr[psrc - 3'd2];
      else nr[pd] = pdat;
    end
    ma = na; mb = nb; ml = nl;
    for (int i = 0; i < 4; i++) mr[i] = nr[i];
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 3'd0, 0, 0, 3'd0, 2'd0, 24'h0, 0, 0, 56'h0);
  endtask

  task automatic load(input string tag, input bit ws, input logic [55:0] wd);
    step(tag, 0, 0, 3'd0, 0, 0, 3'd0, 2'd0, 24'h0, 1, ws, wd);
  endtask

  task automatic drain();
    @(negedge clk);
    xfer_valid = 0; pm_valid = 0; acc_we = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    rst_ni = 1'b0;
    ma = '0; mb = '0; ml = 1'b0;
    for (int i = 0; i < 4; i++) mr[i] = '0;
    #3;
    check("R1 reset state", dut_snap(), model_snap());
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_ni && exp_q.size() != 0) check(tag_q.pop_front(), dut_snap(), exp_q.pop_front());
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 loads
    load("R9 load A", 0, 56'h01_234567_89ABCD);
    load("R9 load B", 1, 56'hFF_FFFFFF_FFFFFF);
    // R2 / R7: exact copy, flag must stay clear
    step("R2 R7 exact A->B", 1, 0, 3'd0, 1, 0, 3'd0, 2'd0, 24'h0, 0, 0, 56'h0);
    load("R9 load B neg ovf", 1, 56'h80_123456_000001);
    step("R2 exact B->A", 1, 0, 3'd1, 0, 0, 3'd0, 2'd0, 24'h0, 0, 0, 56'h0);
    // R6 external word into X0
    step("R6 ext -> X0", 0, 0, 3'd0, 0, 1, 3'd6, 2'd0, 24'h800001, 0, 0, 56'h0);
    // R3 register source, negative
    step("R3 X0 -> B", 1, 0, 3'd2, 1, 0, 3'd0, 2'd0, 24'h0, 0, 0, 56'h0);
    // R4 no overflow read via parallel move
    step("R4 R6 B -> Y1 in range", 0, 0, 3'd0, 0, 1, 3'd1, 2'd3, 24'h0, 0, 0, 56'h0);
    // R5 limited plain move of negative overflow
    step("R5 R4 plain A->B neg sat", 1, 1, 3'd0, 1, 0, 3'd0, 2'd0, 24'h0, 0, 0, 56'h0);
    do_reset();
    load("R9 reload A", 0, 56'h01_234567_89ABCD);
    // R6 R7: exact transfer with limiting parallel move
    step("R6 R7 exact A->B + A->X1", 1, 0, 3'd0, 1, 1, 3'd0, 2'd1, 24'h0, 0, 0, 56'h0);
    idle("R7 flag held 1");
    idle("R7 flag held 2");
    // R8 same-cycle read of B
    load("R9 load A small", 0, 56'h00_000010_000000);
    load("R9 load B pos ovf", 1, 56'h05_000000_000000);
    step("R8 A->B with B->Y0", 1, 0, 3'd0, 1, 1, 3'd1, 2'd2, 24'h0, 0, 0, 56'h0);
    // R9 conflict: transfer wins
    step("R9 R3 Y0->B beats load", 1, 0, 3'd4, 1, 0, 3'd0, 2'd0, 24'h0, 1, 1, 56'h12_345678_9ABCDE);
    // R10 reserved transfer source
    step("R10 src6 ignored", 1, 0, 3'd6, 0, 1, 3'd4, 2'd0, 24'h0, 0, 0, 56'h0);
    step("R10 src7 ignored", 1, 1, 3'd7, 1, 0, 3'd0, 2'd0, 24'h0, 0, 0, 56'h0);
    // R3 positive register source, limited mode
    step("R3 X1 -> A sat mode", 1, 1, 3'd3, 0, 0, 3'd0, 2'd0, 24'h0, 0, 0, 56'h0);
    // R4 positive overflow with zero guard byte
    load("R9 load B bit47", 1, 56'h00_800000_000000);
    step("R4 R6 B -> X0 pos sat", 0, 0, 3'd0, 0, 1, 3'd1, 2'd0, 24'h0, 0, 0, 56'h0);
    step("R6 Y1 -> X1 reg copy", 0, 0, 3'd0, 0, 1, 3'd5, 2'd1, 24'h0, 0, 0, 56'h0);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule